// File: doc/BRIEF.md
# Serial Start Pattern Detector

This block watches a serial receive bit stream and looks for a programmable start pattern. Each accepted bit is shifted into a history register, and the newest history is compared on every accepted bit with the configured pattern. The pattern can be one to four bytes long. When the two agree, the block raises a detect pulse and sets a sticky found flag. It then stops searching and passes every later bit straight through as payload. It does this until the host re-arms it with a clear strobe. Preamble and pattern bits are consumed and are never presented as payload.

Input and output bits travel on valid/ready streams. While searching, the block accepts a bit on every cycle in which `s_valid` is high, so `s_ready` is high. After a detect, the input takes the output's back-pressure: `s_ready` follows `m_ready`, and a bit moves only when both sides agree. During a clear cycle `s_ready` is low and no bit moves. The pattern and length inputs are plain configuration levels. The found flag and the pulse are plain status pins. The pulse can feed an external interrupt routing stage.

Top module: `start_pattern_detector`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, `det_flag`, `det_pulse` and `m_valid` are low and `s_ready` is high.
- R2: When the bit that completes a match is accepted, `det_pulse` is high for exactly the one following clock cycle, and `det_flag` becomes high at the same edge.
- R3: `cfg_len` selects the pattern length: 0 is 8 bits, 1 is 16, 2 is 24 and 3 is 32. Only the low N bits of `cfg_pattern` are compared. Pattern bit N-1 is the first bit received and bit 0 is the last. Higher pattern bits have no effect.
- R4: No match is reported until at least N bits have been accepted since reset or the last clear, even when the pattern is all zeros.
- R5: Once `det_flag` is high, it stays high and no further pulse occurs, even if the pattern arrives again, until `host_clear` is asserted.
- R6: While searching, `s_ready` is high and `m_valid` is low, so preamble and pattern bits are never forwarded.
- R7: While `det_flag` is high, `m_valid` equals `s_valid` and `m_bit` equals `s_bit`. `s_ready` follows `m_ready`, so a stalled output holds the input.
- R8: A cycle with `host_clear` high clears the flag, the pulse and the bit history, and `s_ready` is low in that cycle. It works in either state, including during forwarding. Bits received before the clear cannot contribute to a later match.
- R9: Cycles with `s_valid` low do not shift the history. A pattern split by idle cycles is still found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input bit valid |
| s_ready | output | 1 | Input bit accepted |
| s_bit | input | 1 | Input bit value |
| cfg_pattern | input | 32 | Start pattern, last received bit in bit 0 |
| cfg_len | input | 2 | Pattern length code (bytes minus one) |
| host_clear | input | 1 | Clear flag and restart search |
| det_pulse | output | 1 | One-cycle detect pulse |
| det_flag | output | 1 | Sticky pattern-found flag |
| m_valid | output | 1 | Payload bit valid |
| m_ready | input | 1 | Payload bit accepted downstream |
| m_bit | output | 1 | Payload bit value |

## Verification
The bench uses the default build: 8-bit lanes, four lanes and a 32-bit history. This covers every length code, from a single byte up to the full history width. Each length is run behind a 24-bit alternating preamble with unrelated upper pattern bits, so any masking error or early partial match shows up. Directed cases cover an all-zero pattern against a freshly cleared history, a clear in the middle of both a pattern and forwarding, idle gaps and output stalls.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_FOUND  = 1'b1
  } spd_mode_e;
endpackage

// File: rtl/spd_history.sv
module spd_history #(
  parameter int unsigned HIST_W = 32,
  localparam int unsigned CNT_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_nxt,
  output logic [CNT_W-1:0]  fill_nxt
);
  logic [HIST_W-1:0] hist_q;
  logic [CNT_W-1:0]  fill_q;

  // candidate state if the current bit is accepted
  always_comb begin
    hist_nxt = {hist_q[HIST_W-2:0], bit_in};
    fill_nxt = (fill_q == CNT_W'(HIST_W)) ? fill_q : fill_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(hist_q) && $stable(fill_q)); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0) && (hist_q == '0)); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(HIST_W)); // R4
endmodule

// File: rtl/spd_compare.sv
module spd_compare #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANE_CNT = 4,
  localparam int unsigned HIST_W  = LANE_W * LANE_CNT,
  localparam int unsigned SEL_W   = (LANE_CNT > 1) ? $clog2(LANE_CNT) : 1,
  localparam int unsigned CNT_W   = $clog2(HIST_W + 1)
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [CNT_W-1:0]  fill,
  input  logic [HIST_W-1:0] pattern,
  input  logic [SEL_W-1:0]  len_sel,
  output logic              hit
);
  logic [LANE_CNT-1:0] lane_ok;
  int unsigned         need_bits;

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    logic lane_used;
    assign lane_used  = (int'(len_sel) >= g);
    assign lane_ok[g] = !lane_used ||
      (hist[g*LANE_W +: LANE_W] == pattern[g*LANE_W +: LANE_W]);
  end

  always_comb begin
    need_bits = (int'(len_sel) + 1) * LANE_W;
    hit = (&lane_ok) && (int'(fill) >= int'(need_bits));
  end
endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_clear,
  input  logic accept,
  input  logic hit,
  output logic found,
  output logic pulse
);
  spd_mode_e mode_q;
  logic      pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n || host_clear) begin
      mode_q  <= MODE_SEARCH;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (mode_q == MODE_SEARCH && accept && hit) begin
        mode_q  <= MODE_FOUND;
        pulse_q <= 1'b1;
      end
    end
  end

  assign found = (mode_q == MODE_FOUND);
  assign pulse = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R2
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> found); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !host_clear) |=> found && !pulse); // R5
  AST_CLEAR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |=> !found && !pulse); // R8
endmodule

// File: rtl/start_pattern_detector.sv
module start_pattern_detector #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANE_CNT = 4,
  localparam int unsigned HIST_W  = LANE_W * LANE_CNT,
  localparam int unsigned SEL_W   = (LANE_CNT > 1) ? $clog2(LANE_CNT) : 1,
  localparam int unsigned CNT_W   = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_bit,
  input  logic [HIST_W-1:0] cfg_pattern,
  input  logic [SEL_W-1:0]  cfg_len,
  input  logic              host_clear,
  output logic              det_pulse,
  output logic              det_flag,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_bit
);
  logic              accept;
  logic              shift_en;
  logic              hit;
  logic [HIST_W-1:0] hist_nxt;
  logic [CNT_W-1:0]  fill_nxt;

  // searching: always ready; found: pass-through with back-pressure
  always_comb begin
    if (host_clear)    s_ready = 1'b0;
    else if (det_flag) s_ready = m_ready;
    else               s_ready = 1'b1;
    m_valid  = det_flag && s_valid && !host_clear;
    m_bit    = s_bit;
    accept   = s_valid && s_ready;
    shift_en = accept && !det_flag;
  end

  spd_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (host_clear),
    .shift_en (shift_en),
    .bit_in   (s_bit),
    .hist_nxt (hist_nxt),
    .fill_nxt (fill_nxt)
  );

  spd_compare #(.LANE_W(LANE_W), .LANE_CNT(LANE_CNT)) u_cmp (
    .hist    (hist_nxt),
    .fill    (fill_nxt),
    .pattern (cfg_pattern),
    .len_sel (cfg_len),
    .hit     (hit)
  );

  spd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_clear (host_clear),
    .accept     (accept),
    .hit        (hit),
    .found      (det_flag),
    .pulse      (det_pulse)
  );

  AST_SEARCH_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_flag && !host_clear) |-> s_ready && !m_valid); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R7
  AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |-> !s_ready && !m_valid); // R8
  AST_PULSE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(accept)); // R2
endmodule

// File: tb/tb_start_pattern_detector.sv
module tb_start_pattern_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_bit = 1'b0;
  logic [31:0] cfg_pattern = '0;
  logic [1:0]  cfg_len = '0;
  logic        host_clear = 1'b0;
  logic        det_pulse;
  logic        det_flag;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic        m_bit;

  int checks = 0;
  int failures = 0;
  logic pulse_seen;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  start_pattern_detector dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .cfg_pattern(cfg_pattern), .cfg_len(cfg_len), .host_clear(host_clear),
    .det_pulse(det_pulse), .det_flag(det_flag), .m_valid(m_valid),
    .m_ready(m_ready), .m_bit(m_bit)
  );

  // {length code, pattern}; upper unused pattern bits carry junk (R3)
  localparam logic [33:0] VECS [4] = '{
    {2'd0, 32'hABCDEFD3},
    {2'd1, 32'h9876C5A7},
    {2'd2, 32'h55E13B6D},
    {2'd3, 32'hF0C3A596}
  };
  localparam logic [23:0] PREAMBLE = 24'hAAAAAA;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; drives one cycle, records pulse after the edge
  task automatic step(input logic v, input logic b);
    s_valid = v;
    s_bit = b;
    @(negedge clk);
    pulse_seen = det_pulse;
  endtask

  task automatic do_clear();
    s_valid = 1'b0;
    host_clear = 1'b1;
    @(negedge clk);
    host_clear = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int early;
    int n;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!det_flag && !det_pulse && !m_valid && s_ready, "R1 in reset",
        {det_flag, det_pulse, m_valid, s_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!det_flag && !det_pulse && !m_valid && s_ready, "R1 after reset",
        {det_flag, det_pulse, m_valid, s_ready}, 1);

    // table walk: preamble + pattern for every length code (R2, R3, R6)
    for (int v = 0; v < 4; v++) begin
      do_clear();
      cfg_len = VECS[v][33:32];
      cfg_pattern = VECS[v][31:0];
      n = (v + 1) * 8;
      early = 0;
      for (int i = 23; i >= 0; i--) begin
        s_valid = 1'b1; s_bit = PREAMBLE[i];
        #1;
        if (m_valid || !s_ready) early++;
        step(1'b1, PREAMBLE[i]);
        if (pulse_seen || det_flag) early++;
      end
      for (int i = n - 1; i >= 1; i--) begin
        step(1'b1, cfg_pattern[i]);
        if (pulse_seen || det_flag || m_valid) early++;
      end
      chk(early == 0, "R6 no early detect or forward", early, 0);
      step(1'b1, cfg_pattern[0]);
      chk(pulse_seen && det_flag, "R2 R3 detect on last pattern bit",
          {pulse_seen, det_flag}, 3);
      step(1'b0, 1'b0);
      chk(!pulse_seen && det_flag, "R2 pulse lasts one cycle", {pulse_seen, det_flag}, 1);
    end

    // R7 forwarding and back-pressure
    m_ready = 1'b0; s_valid = 1'b1; s_bit = 1'b1;
    #1;
    chk(m_valid && !s_ready && m_bit, "R7 stalled output", {m_valid, s_ready, m_bit}, 5);
    m_ready = 1'b1; s_bit = 1'b0;
    #1;
    chk(m_valid && s_ready && !m_bit, "R7 forwarding", {m_valid, s_ready, m_bit}, 6);
    s_valid = 1'b0;
    #1;
    chk(!m_valid, "R7 no valid without input", m_valid, 0);
    @(negedge clk);

    // R4 all-zero pattern needs eight bits after clear
    do_clear();
    cfg_len = 2'd0; cfg_pattern = 32'h0;
    early = 0;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 1'b0);
      if (pulse_seen || det_flag) early++;
    end
    chk(early == 0, "R4 no match before eight bits", early, 0);
    step(1'b1, 1'b0);
    chk(pulse_seen, "R4 match at eighth bit", pulse_seen, 1);

    // R5 sticky: pattern again while found
    early = 0;
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b0);
      if (pulse_seen) early++;
    end
    chk(early == 0 && det_flag, "R5 no second pulse, flag holds", early, 0);

    // R8 clear during forwarding and mid-pattern
    cfg_pattern = 32'h000000D3;
    s_valid = 1'b0; host_clear = 1'b1;
    #1;
    chk(!s_ready, "R8 not ready during clear", s_ready, 0);
    @(negedge clk);
    host_clear = 1'b0;
    chk(!det_flag && !det_pulse, "R8 clear ends forwarding", det_flag, 0);
    step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1);
    do_clear();
    early = 0;
    step(1'b1, 1'b0); if (pulse_seen) early++;
    step(1'b1, 1'b0); if (pulse_seen) early++;
    step(1'b1, 1'b1); if (pulse_seen) early++;
    step(1'b1, 1'b1); if (pulse_seen || det_flag) early++;
    chk(early == 0, "R8 old bits do not complete a match", early, 0);
    for (int i = 7; i >= 1; i--) begin
      step(1'b1, cfg_pattern[i]);
      if (pulse_seen) early++;
    end
    step(1'b1, cfg_pattern[0]);
    chk(pulse_seen && early == 0, "R8 fresh pattern found after clear", pulse_seen, 1);

    // R9 idle gaps inside the pattern, junk bit on idle cycles
    do_clear();
    early = 0;
    for (int i = 7; i >= 1; i--) begin
      step(1'b1, cfg_pattern[i]);
      if (pulse_seen) early++;
      step(1'b0, ~cfg_pattern[i]);
      if (pulse_seen) early++;
    end
    step(1'b1, cfg_pattern[0]);
    chk(pulse_seen && early == 0, "R9 gapped pattern found", {pulse_seen}, 1);

    s_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule